// File: doc/BRIEF.md
# Floating-Point NaN Result Resolver

This block sits at the result stage of a floating-point datapath. It looks at the operands of the current operation and decides whether the normal arithmetic result must be replaced by a NaN. If so, it also decides which NaN to return and whether the invalid-operation exception applies. It handles two-operand arithmetic and three-operand fused multiply-add. The format is single or double, chosen by a parameter. The NaN value itself is the only result it computes; the arithmetic, rounding and denormal flushing belong elsewhere.

A per-operation mode input chooses between two NaN conventions.

- In legacy mode, a NaN whose top fraction bit is set is signaling, and every NaN result is replaced by a fixed default pattern.
- In 2008 mode, a NaN whose top fraction bit is clear is signaling. An input NaN is passed through after it is quieted, and a fixed priority order decides which input NaN wins.

The fused infinity-times-zero-plus-NaN case has its own handling. An optional output register adds one cycle of latency.

Top module: `nanres_unit`

## Requirements
- R1: Signaling detection depends on the mode. With `mode_2008`=0, a NaN with fraction bit F-1 = 1 is signaling and one with that bit 0 is quiet. With `mode_2008`=1 the meaning is reversed. A NaN is any value with the exponent all ones and a non-zero fraction. F is 23 for single format and 52 for double.
- R2: With `mode_2008`=0, every overriding result is the legacy default NaN. This pattern has the sign 0, the exponent all ones, fraction bit F-1 = 0 and all lower fraction bits 1. In single format it is 0x7FBFFFFF.
- R3: In two-operand mode (`three_op`=0) with `mode_2008`=1, the propagated operand is chosen in this order: A if signaling, B if signaling, A if quiet, B if quiet.
- R4: In 2008 mode, a propagated operand has fraction bit F-1 forced to 1. Its sign, exponent and all other fraction bits are unchanged.
- R5: In three-operand mode with `mode_2008`=1, signaling NaNs are examined first in the order C, A, B. Quiet NaNs are then examined in the same order C, A, B.
- R6: In three-operand mode, when A and B are infinity and zero (in either order) and C is a NaN, `invalid` is raised. Legacy mode returns the legacy default NaN; 2008 mode returns C after quieting.
- R7: `invalid` is 1 exactly when a considered operand is a signaling NaN or the R6 case applies. The considered operands are A and B, plus C in three-operand mode.
- R8: When no considered operand is a NaN, `nan_take` and `invalid` are 0 and `nan_value` is 0.
- R9: In two-operand mode, operand C has no effect on any output.
- R10: With `REG_OUT`=1 (the default), outputs reflect the inputs of the previous clock edge. A synchronous reset clears all outputs to 0.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Clock for the optional output register |
| rst | input | 1 | Synchronous active-high reset |
| mode_2008 | input | 1 | 1 selects 2008 NaN rules, 0 selects legacy rules |
| three_op | input | 1 | 1 for fused multiply-add (A*B+C), 0 for two-operand operations |
| opnd_a | input | W | Operand A (W = 32 or 64) |
| opnd_b | input | W | Operand B |
| opnd_c | input | W | Operand C, used only in three-operand mode |
| nan_take | output | 1 | The NaN result replaces the normal arithmetic result |
| nan_value | output | W | NaN result value, 0 when `nan_take` is 0 |
| invalid | output | 1 | Invalid-operation exception |

## Verification
The assertions assume that the mode, the operation type and the operands stay stable for the whole cycle in which they are captured. They also assume that their delayed copies in the checker line up with the output register latency.

The stimulus drives every input once per cycle, just after the falling edge, and holds each value until the next one. It draws operands from a pool of zeros, infinities, ordinary numbers, and quiet and signaling NaNs of both signs and conventions. This pool lets the priority orders, the infinity-times-zero case and the ignored third operand all occur often.

// File: rtl/nanres_pkg.sv
package nanres_pkg;

    // Classification of one operand under the active NaN convention
    typedef struct packed {
        logic nan;
        logic snan;
        logic qnan;
        logic inf;
        logic zero;
    } fp_kind_t;

    // Which value drives the NaN result
    typedef enum logic [2:0] {
        SRC_NONE = 3'd0,
        SRC_A    = 3'd1,
        SRC_B    = 3'd2,
        SRC_C    = 3'd3,
        SRC_DFLT = 3'd4
    } src_sel_t;

    typedef struct packed {
        src_sel_t src;
        logic     invalid;
    } pick_t;

endpackage

// File: rtl/nanres_classify.sv
module nanres_classify
    import nanres_pkg::*;
#(
    parameter int EXP_W  = 8,
    parameter int FRAC_W = 23,
    localparam int W     = 1 + EXP_W + FRAC_W
) (
    input  logic [W-1:0] val,
    input  logic         mode_2008,
    output fp_kind_t     kind
);
    logic [EXP_W-1:0]  exp_f;
    logic [FRAC_W-1:0] frac_f;
    logic              exp_ones;
    logic              frac_nz;
    logic              top_bit;

    always_comb begin
        exp_f    = val[W-2 -: EXP_W];
        frac_f   = val[FRAC_W-1:0];
        exp_ones = &exp_f;
        frac_nz  = |frac_f;
        top_bit  = frac_f[FRAC_W-1];

        kind.nan  = exp_ones & frac_nz;
        // legacy: top fraction bit set means signaling; 2008: clear means signaling
        kind.snan = kind.nan & (mode_2008 ? ~top_bit : top_bit);
        kind.qnan = kind.nan & ~kind.snan;
        kind.inf  = exp_ones & ~frac_nz;
        kind.zero = ~|val[W-2:0];
    end
endmodule

// File: rtl/nanres_select.sv
module nanres_select
    import nanres_pkg::*;
(
    input  fp_kind_t ka,
    input  fp_kind_t kb,
    input  fp_kind_t kc,
    input  logic     three_op,
    input  logic     mode_2008,
    output pick_t    pick
);
    logic c_snan, c_qnan, c_nan;
    logic inf_x_zero;
    logic any_nan;

    always_comb begin
        c_snan     = three_op & kc.snan;
        c_qnan     = three_op & kc.qnan;
        c_nan      = three_op & kc.nan;
        inf_x_zero = three_op & c_nan &
                     ((ka.inf & kb.zero) | (ka.zero & kb.inf));
        any_nan    = ka.nan | kb.nan | c_nan;

        pick.invalid = inf_x_zero | ka.snan | kb.snan | c_snan;

        if (!any_nan)          pick.src = SRC_NONE;
        else if (!mode_2008)   pick.src = SRC_DFLT;
        else if (inf_x_zero)   pick.src = SRC_C;
        else if (three_op) begin
            if (c_snan)        pick.src = SRC_C;
            else if (ka.snan)  pick.src = SRC_A;
            else if (kb.snan)  pick.src = SRC_B;
            else if (c_qnan)   pick.src = SRC_C;
            else if (ka.qnan)  pick.src = SRC_A;
            else               pick.src = SRC_B;
        end else begin
            if (ka.snan)       pick.src = SRC_A;
            else if (kb.snan)  pick.src = SRC_B;
            else if (ka.qnan)  pick.src = SRC_A;
            else               pick.src = SRC_B;
        end
    end
endmodule

// File: rtl/nanres_unit.sv
module nanres_unit
    import nanres_pkg::*;
#(
    parameter bit IS_DOUBLE = 1'b0,
    parameter bit REG_OUT   = 1'b1,
    localparam int EXP_W    = IS_DOUBLE ? 11 : 8,
    localparam int FRAC_W   = IS_DOUBLE ? 52 : 23,
    localparam int W        = 1 + EXP_W + FRAC_W
) (
    input  logic         clk,
    input  logic         rst,
    input  logic         mode_2008,
    input  logic         three_op,
    input  logic [W-1:0] opnd_a,
    input  logic [W-1:0] opnd_b,
    input  logic [W-1:0] opnd_c,
    output logic         nan_take,
    output logic [W-1:0] nan_value,
    output logic         invalid
);
    localparam logic [W-1:0] LEGACY_DFLT =
        {1'b0, {EXP_W{1'b1}}, 1'b0, {(FRAC_W-1){1'b1}}};
    localparam logic [W-1:0] QUIET_MASK = W'(1) << (FRAC_W-1);

    fp_kind_t    kinds [3];
    logic [W-1:0] opnds [3];
    pick_t       pick;
    logic        take_c;
    logic [W-1:0] value_c;

    assign opnds[0] = opnd_a;
    assign opnds[1] = opnd_b;
    assign opnds[2] = opnd_c;

    for (genvar i = 0; i < 3; i++) begin : g_cls
        nanres_classify #(.EXP_W(EXP_W), .FRAC_W(FRAC_W)) u_cls (
            .val       (opnds[i]),
            .mode_2008 (mode_2008),
            .kind      (kinds[i])
        );
    end

    nanres_select u_sel (
        .ka        (kinds[0]),
        .kb        (kinds[1]),
        .kc        (kinds[2]),
        .three_op  (three_op),
        .mode_2008 (mode_2008),
        .pick      (pick)
    );

    always_comb begin
        take_c = (pick.src != SRC_NONE);
        unique case (pick.src)
            SRC_A:    value_c = opnd_a | QUIET_MASK;
            SRC_B:    value_c = opnd_b | QUIET_MASK;
            SRC_C:    value_c = opnd_c | QUIET_MASK;
            SRC_DFLT: value_c = LEGACY_DFLT;
            default:  value_c = '0;
        endcase
    end

    if (REG_OUT) begin : g_reg
        always_ff @(posedge clk) begin
            if (rst) begin
                nan_take  <= 1'b0;
                nan_value <= '0;
                invalid   <= 1'b0;
            end else begin
                nan_take  <= take_c;
                nan_value <= value_c;
                invalid   <= pick.invalid;
            end
        end
    end else begin : g_comb
        assign nan_take  = take_c;
        assign nan_value = value_c;
        assign invalid   = pick.invalid;
    end
endmodule

// File: rtl/nanres_checker.sv
module nanres_checker #(
    parameter bit IS_DOUBLE = 1'b0,
    parameter bit REG_OUT   = 1'b1,
    localparam int EXP_W    = IS_DOUBLE ? 11 : 8,
    localparam int FRAC_W   = IS_DOUBLE ? 52 : 23,
    localparam int W        = 1 + EXP_W + FRAC_W
) (
    input logic         clk,
    input logic         rst,
    input logic         mode_2008,
    input logic         three_op,
    input logic [W-1:0] opnd_a,
    input logic [W-1:0] opnd_b,
    input logic [W-1:0] opnd_c,
    input logic         nan_take,
    input logic [W-1:0] nan_value,
    input logic         invalid
);
    localparam logic [W-1:0] LEG = {1'b0, {EXP_W{1'b1}}, 1'b0, {(FRAC_W-1){1'b1}}};

    logic         mode_d, three_d;
    logic [W-1:0] a_d, b_d, c_d;

    if (REG_OUT) begin : g_dly
        always_ff @(posedge clk) begin
            if (rst) begin
                mode_d <= 1'b0; three_d <= 1'b0;
                a_d <= '0; b_d <= '0; c_d <= '0;
            end else begin
                mode_d <= mode_2008; three_d <= three_op;
                a_d <= opnd_a; b_d <= opnd_b; c_d <= opnd_c;
            end
        end
    end else begin : g_nodly
        assign mode_d = mode_2008; assign three_d = three_op;
        assign a_d = opnd_a; assign b_d = opnd_b; assign c_d = opnd_c;
    end

    function automatic logic is_nan(input logic [W-1:0] v);
        return (&v[W-2 -: EXP_W]) && (|v[FRAC_W-1:0]);
    endfunction

    p_invalid_implies_take_r7: assert property (@(posedge clk) disable iff (rst)
        invalid |-> nan_take);

    p_idle_zero_r8: assert property (@(posedge clk) disable iff (rst)
        !nan_take |-> (nan_value == '0 && !invalid));

    p_legacy_default_r2: assert property (@(posedge clk) disable iff (rst)
        (nan_take && !mode_d) |-> nan_value == LEG);

    p_quiet_out_r4: assert property (@(posedge clk) disable iff (rst)
        (nan_take && mode_d) |-> (is_nan(nan_value) && nan_value[FRAC_W-1]));

    p_pick_quiet_a_r3: assert property (@(posedge clk) disable iff (rst)
        (mode_d && !three_d && is_nan(a_d) && a_d[FRAC_W-1] && !is_nan(b_d))
        |-> (nan_take && nan_value == a_d));

    p_ignore_c_r9: assert property (@(posedge clk) disable iff (rst)
        (!three_d && !is_nan(a_d) && !is_nan(b_d)) |-> (!nan_take && !invalid));
endmodule

bind nanres_unit nanres_checker #(.IS_DOUBLE(IS_DOUBLE), .REG_OUT(REG_OUT)) u_chk (
    .clk(clk), .rst(rst), .mode_2008(mode_2008), .three_op(three_op),
    .opnd_a(opnd_a), .opnd_b(opnd_b), .opnd_c(opnd_c),
    .nan_take(nan_take), .nan_value(nan_value), .invalid(invalid)
);

// File: tb/tb_nanres_unit.sv
module tb_nanres_unit;
    localparam int W = 32;

    logic clk = 1'b0;
    logic rst = 1'b1;
    logic mode_2008 = 1'b0, three_op = 1'b0;
    logic [W-1:0] opnd_a = '0, opnd_b = '0, opnd_c = '0;
    logic nan_take, invalid;
    logic [W-1:0] nan_value;

    int n_tests = 0, n_fail = 0;
    bit done = 1'b0;

    always #4 clk = ~clk;

    nanres_unit dut (
        .clk(clk), .rst(rst), .mode_2008(mode_2008), .three_op(three_op),
        .opnd_a(opnd_a), .opnd_b(opnd_b), .opnd_c(opnd_c),
        .nan_take(nan_take), .nan_value(nan_value), .invalid(invalid)
    );

    // behavioural reference
    function automatic bit r_nan(input logic [31:0] v);
        return v[30:23] == 8'hFF && v[22:0] != 0;
    endfunction
    function automatic bit r_sig(input logic [31:0] v, input bit m);
        return r_nan(v) && (v[22] == !m);
    endfunction
    function automatic bit r_inf(input logic [31:0] v);
        return v[30:0] == 31'h7F80_0000;
    endfunction
    function automatic bit r_zero(input logic [31:0] v);
        return v[30:0] == 0;
    endfunction

    function automatic logic [33:0] ref_out(input bit m, input bit t,
            input logic [31:0] a, input logic [31:0] b, input logic [31:0] c);
        logic [31:0] ops [3];
        int order [3];
        int n;
        bit any, inv, izn;
        logic [31:0] v;
        ops[0] = a; ops[1] = b; ops[2] = c;
        n = t ? 3 : 2;
        if (t && m) begin order[0] = 2; order[1] = 0; order[2] = 1; end
        else begin order[0] = 0; order[1] = 1; order[2] = 2; end
        any = 0; inv = 0; v = 0;
        for (int i = 0; i < n; i++) begin
            if (r_nan(ops[i])) any = 1;
            if (r_sig(ops[i], m)) inv = 1;
        end
        izn = t && r_nan(c) && ((r_inf(a) && r_zero(b)) || (r_zero(a) && r_inf(b)));
        if (izn) inv = 1;
        if (any) begin
            if (!m) v = 32'h7FBF_FFFF;
            else begin
                bit found = 0;
                for (int pass = 0; pass < 2; pass++)
                    for (int k = 0; k < n; k++)
                        if (!found && r_nan(ops[order[k]]) &&
                            (r_sig(ops[order[k]], m) == (pass == 0))) begin
                            v = ops[order[k]] | 32'h0040_0000;
                            found = 1;
                        end
            end
        end
        return {any, inv, v};
    endfunction

    logic [33:0] exp_q [$];
    string       tag_q [$];

    task automatic check_now();
        logic [33:0] e;
        string tg;
        if (exp_q.size() == 0) return;
        e = exp_q.pop_front();
        tg = tag_q.pop_front();
        n_tests++;
        if ({nan_take, invalid, nan_value} !== e) begin
            n_fail++;
            $display("FAIL %s: got take=%0b inv=%0b val=%08h expected take=%0b inv=%0b val=%08h",
                     tg, nan_take, invalid, nan_value, e[33], e[32], e[31:0]);
        end
    endtask

    // apply at negedge, result checked at the following negedge
    task automatic apply(input bit m, input bit t, input logic [31:0] a,
                         input logic [31:0] b, input logic [31:0] c, input string tg);
        @(negedge clk);
        check_now();
        mode_2008 = m; three_op = t; opnd_a = a; opnd_b = b; opnd_c = c;
        exp_q.push_back(ref_out(m, t, a, b, c));
        tag_q.push_back(tg);
    endtask

    logic [31:0] pool [12];
    initial begin
        pool[0] = 32'h0000_0000; pool[1] = 32'h3F80_0000; pool[2] = 32'h7F80_0000;
        pool[3] = 32'hFF80_0000; pool[4] = 32'h8000_0000; pool[5] = 32'h7FC0_0000;
        pool[6] = 32'h7FC0_1234; pool[7] = 32'hFFC0_0001; pool[8] = 32'h7F80_0001;
        pool[9] = 32'h7FA0_0000; pool[10] = 32'hFF81_2345; pool[11] = 32'h4049_0FDB;
    end

    initial begin
        repeat (3) @(negedge clk);
        // R10: reset clears outputs
        n_tests++;
        if (nan_take !== 1'b0 || invalid !== 1'b0 || nan_value !== '0) begin
            n_fail++;
            $display("FAIL R10: reset got take=%0b inv=%0b val=%08h expected 0 0 00000000",
                     nan_take, invalid, nan_value);
        end
        rst = 1'b0;

        // R8: ordinary operands
        apply(1, 0, 32'h3F80_0000, 32'h4049_0FDB, 32'h0, "R8 no nan 2op");
        apply(0, 1, 32'h3F80_0000, 32'h0, 32'h4000_0000, "R8 no nan 3op");
        // R1/R2 legacy: quiet (msb 0) and signaling (msb 1)
        apply(0, 0, 32'h7F80_0001, 32'h3F80_0000, 32'h0, "R1 R2 legacy quiet A");
        apply(0, 0, 32'h3F80_0000, 32'h7FC0_0000, 32'h0, "R1 R2 legacy signaling B");
        // R1 2008: msb 1 quiet, msb 0 signaling
        apply(1, 0, 32'h7FC0_0000, 32'h0, 32'h0, "R1 2008 quiet A no invalid");
        apply(1, 0, 32'h7F80_0001, 32'h0, 32'h0, "R1 R4 2008 signaling A quieted");
        // R3 priority
        apply(1, 0, 32'h7FC0_1234, 32'hFF81_2345, 32'h0, "R3 sB beats qA");
        apply(1, 0, 32'h7FA0_0000, 32'hFF81_2345, 32'h0, "R3 sA beats sB");
        apply(1, 0, 32'hFFC0_0001, 32'h7FC0_1234, 32'h0, "R3 qA beats qB");
        apply(1, 0, 32'h3F80_0000, 32'hFFC0_0001, 32'h0, "R3 qB alone");
        // R4 payload kept
        apply(1, 0, 32'hFFA5_5AA5, 32'h0, 32'h0, "R4 sign and payload kept");
        // R5 three-operand order
        apply(1, 1, 32'h7FA0_0000, 32'hFF81_2345, 32'h7F80_0003, "R5 sC first");
        apply(1, 1, 32'h7FC0_1234, 32'hFF81_2345, 32'h7FC0_0007, "R5 sB beats qC");
        apply(1, 1, 32'h7FC0_1234, 32'hFFC0_0001, 32'h7FC0_0007, "R5 qC beats qA");
        apply(1, 1, 32'h3F80_0000, 32'hFFC0_0001, 32'h4000_0000, "R5 qB alone");
        // R6 inf*0+NaN
        apply(0, 1, 32'h7F80_0000, 32'h8000_0000, 32'h7F80_0001, "R6 legacy izn");
        apply(1, 1, 32'h0000_0000, 32'hFF80_0000, 32'h7FC0_0042, "R6 2008 izn quiet C");
        apply(1, 1, 32'h7F80_0000, 32'h0000_0000, 32'h7F80_0042, "R6 2008 izn sig C");
        // R7 invalid from inf*0 without NaN C stays out of scope -> low
        apply(1, 1, 32'h7F80_0000, 32'h0000_0000, 32'h3F80_0000, "R7 R8 izn without nan");
        // R9: C ignored in two-op mode
        apply(1, 0, 32'h3F80_0000, 32'h0, 32'h7F80_0001, "R9 sNaN C ignored");
        apply(0, 0, 32'h3F80_0000, 32'h0, 32'h7FC0_0000, "R9 legacy C ignored");

        // mixed patterns from the special-value pool
        for (int i = 0; i < 400; i++)
            apply($urandom_range(0, 1), $urandom_range(0, 1),
                  pool[$urandom_range(0, 11)], pool[$urandom_range(0, 11)],
                  pool[$urandom_range(0, 11)], "R1 R2 R3 R5 R6 R7 R9 pool");

        // R10: reset mid-stream clears outputs
        apply(1, 0, 32'h7FC0_0000, 32'h0, 32'h0, "R10 before reset");
        @(negedge clk);
        check_now();
        rst = 1'b1;
        @(negedge clk);
        n_tests++;
        if (nan_take !== 1'b0 || invalid !== 1'b0 || nan_value !== '0) begin
            n_fail++;
            $display("FAIL R10: sync reset got take=%0b inv=%0b val=%08h expected 0 0 00000000",
                     nan_take, invalid, nan_value);
        end
        done = 1'b1;
    end

    initial begin
        fork
            wait (done);
            begin
                repeat (20000) @(posedge clk);
                n_tests++; n_fail++;
                $display("FAIL watchdog: got timeout expected completion");
            end
        join_any
        $display("[TB] %0d tests run, %0d failed", n_tests, n_fail);
        $finish;
    end
endmodule